// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block moves 8-bit data between two buses, called side A and side B, in either direction. Each side has its own storage register with its own capture clock. For each direction a select chooses between the live value on the opposite bus and the value held in the register. An enable decides whether that direction drives its target bus at all. The three-state pins of each bus are split into a data-in port, a data-out port and an output-enable port, so that pad buffers can be added at chip level.

Each direction is decoded into one of three named path modes:

- `PATH_IDLE`: the enable is off. The output enable is low and the data output is held at zero.
- `PATH_LIVE`: the enable is on and the select is low. The opposite bus input passes straight through.
- `PATH_REPLAY`: the enable is on and the select is high. The stored register value is driven.

The mode follows the enable and select levels directly. The transitions are IDLE→LIVE or IDLE→REPLAY when the enable asserts, LIVE↔REPLAY when the select toggles, and either active mode →IDLE when the enable drops. The mode has no memory, so a change of select moves the output from one defined source to the other with no intermediate value.

A register loads on the rising edge of its clock. It loads the bus as the block sees it: the external input when the block is not driving that bus, or the block's own output when it is. Registers load in every path mode. With both directions live, each output depends only on the other side's external input, so there is no combinational loop.

Top module: `bidir_store_xcvr`

## Requirements
- R1: Asserting `rst_n` low clears both storage registers to 8'h00.
- R2: A rising edge on `clk_ab` loads the A-side register. Its contents are then visible through replay on bus B.
- R3: A rising edge on `clk_ba` loads the B-side register, independently of the A-side register.
- R4: `b_oe` equals `en_ab` (active high). When `en_ab` is 0, `b_out` is 8'h00.
- R5: `a_oe` equals the inverse of `en_ba_n` (active low). When `en_ba_n` is 1, `a_out` is 8'h00.
- R6: When bus B is driven with `sel_ab`=0, `b_out` equals `a_in` bit for bit, with no inversion.
- R7: When bus B is driven with `sel_ab`=1, `b_out` equals the A-side register.
- R8: When bus A is driven, `a_out` equals `b_in` for `sel_ba`=0 and the B-side register for `sel_ba`=1.
- R9: While a bus is driven by the block, its register loads the block's own output on that bus instead of the external input.
- R10: A register keeps its value across cycles with no rising edge on its clock, even while bus inputs change.
- R11: With both directions enabled and live, `b_out` follows `a_in` and `a_out` follows `b_in` simultaneously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| en_ab | input | 1 | Active-high enable for driving bus B |
| en_ba_n | input | 1 | Active-low enable for driving bus A |
| sel_ab | input | 1 | Source toward B: 0 live A input, 1 A-side register |
| sel_ba | input | 1 | Source toward A: 0 live B input, 1 B-side register |
| a_in | input | 8 | Value of bus A as driven from outside |
| a_out | output | 8 | Value the block drives on bus A |
| a_oe | output | 1 | Output enable of bus A |
| b_in | input | 8 | Value of bus B as driven from outside |
| b_out | output | 8 | Value the block drives on bus B |
| b_oe | output | 1 | Output enable of bus B |

## Verification
At every register clock edge, the assertions check that each register took the value presented to it on the previous edge. They also check that each output enable tracks its enable with the right polarity, that an idle path drives zero, and that a live or replay path drives exactly its chosen source. Only the bench scenarios can show end-to-end effects that span several cycles. These are values surviving many idle cycles, capture of the block's own driven value followed by replay, independence between the two registers, reset contents, and both directions running live at the same time.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

    localparam int BSX_WIDTH = 8;

    typedef enum logic [1:0] {
        PATH_IDLE   = 2'd0,
        PATH_LIVE   = 2'd1,
        PATH_REPLAY = 2'd2
    } path_mode_e;

endpackage

// File: rtl/bsx_store_reg.sv
module bsx_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] CLEAR_VAL = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CLEAR_VAL;
        end else begin
            q <= d;
        end
    end

    // R2 / R3: the value presented at one edge is what the register holds at the next
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/bsx_drive_path.sv
module bsx_drive_path
    import bsx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic         oe,
    output logic [W-1:0] dout
);

    path_mode_e mode;

    // mode follows levels only: no hidden state, so a select change never passes an undefined value
    always_comb begin
        if (!en) begin
            mode = PATH_IDLE;
        end else if (sel) begin
            mode = PATH_REPLAY;
        end else begin
            mode = PATH_LIVE;
        end
    end

    always_comb begin
        unique case (mode)
            PATH_IDLE: begin
                oe   = 1'b0;
                dout = '0;
            end
            PATH_LIVE: begin
                oe   = 1'b1;
                dout = live;
            end
            PATH_REPLAY: begin
                oe   = 1'b1;
                dout = stored;
            end
            default: begin
                oe   = 1'b0;
                dout = '0;
            end
        endcase
    end

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr
    import bsx_pkg::*;
#(
    parameter int W = BSX_WIDTH
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst_n,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] reg_a_q;
    logic [W-1:0] reg_b_q;
    logic [W-1:0] reg_a_d;
    logic [W-1:0] reg_b_d;
    logic         drive_a_en;

    assign drive_a_en = ~en_ba_n;

    // R9: each register loads the bus as resolved, i.e. the block's own value when it drives
    always_comb begin
        reg_a_d = a_oe ? a_out : a_in;
        reg_b_d = b_oe ? b_out : b_in;
    end

    bsx_store_reg #(.W(W)) u_reg_a (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (reg_a_d),
        .q     (reg_a_q)
    );

    bsx_store_reg #(.W(W)) u_reg_b (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (reg_b_d),
        .q     (reg_b_q)
    );

    // toward bus B: live A input or A-side register
    bsx_drive_path #(.W(W)) u_path_to_b (
        .en     (en_ab),
        .sel    (sel_ab),
        .live   (a_in),
        .stored (reg_a_q),
        .oe     (b_oe),
        .dout   (b_out)
    );

    // toward bus A: live B input or B-side register
    bsx_drive_path #(.W(W)) u_path_to_a (
        .en     (drive_a_en),
        .sel    (sel_ba),
        .live   (b_in),
        .stored (reg_b_q),
        .oe     (a_oe),
        .dout   (a_out)
    );

    p_oe_b_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (b_oe == en_ab) && (!en_ab -> (b_out == '0)));

    p_oe_a_r5: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (a_oe == !en_ba_n) && (en_ba_n -> (a_out == '0)));

    p_live_b_r6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (en_ab && !sel_ab) |-> (b_out == a_in));

    p_replay_b_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (en_ab && sel_ab) |-> (b_out == reg_a_q));

    p_path_a_r8: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !en_ba_n |-> (a_out == (sel_ba ? reg_b_q : b_in)));

endmodule

// File: tb/test_bidir_store_xcvr.sv
module test_bidir_store_xcvr;

    localparam int W = 8;

    typedef struct packed {
        logic         a_oe;
        logic [W-1:0] a_out;
        logic         b_oe;
        logic [W-1:0] b_out;
    } exp_t;

    logic         tclk = 1'b0;
    logic         gate_a = 1'b0;
    logic         gate_b = 1'b0;
    logic         clk_ab;
    logic         clk_ba;
    logic         rst_n = 1'b0;
    logic         en_ab = 1'b0;
    logic         en_ba_n = 1'b1;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    exp_t  exp_q[$];
    string tag_q[$];
    event  mon_ev;

    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;

    always #4 tclk = ~tclk;  // 125 MHz

    // gates change only while tclk is low, so the derived clocks never glitch
    assign clk_ab = tclk & gate_a;
    assign clk_ba = tclk & gate_b;

    bidir_store_xcvr #(.W(W)) i_bidir_store_xcvr (
        .clk_ab  (clk_ab),
        .clk_ba  (clk_ba),
        .rst_n   (rst_n),
        .en_ab   (en_ab),
        .en_ba_n (en_ba_n),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .a_in    (a_in),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_in    (b_in),
        .b_out   (b_out),
        .b_oe    (b_oe)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  got;
                string t;
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                got = '{a_oe: a_oe, a_out: a_out, b_oe: b_oe, b_out: b_out};
                total++;
                if (got !== e) begin
                    bad++;
                    $display("FAIL %s: got a_oe=%b a_out=%h b_oe=%b b_out=%h exp a_oe=%b a_out=%h b_oe=%b b_out=%h",
                             t, got.a_oe, got.a_out, got.b_oe, got.b_out,
                             e.a_oe, e.a_out, e.b_oe, e.b_out);
                end
            end
        end
    end

    // driver: applies one cycle of stimulus, predicts outputs, then predicts captures
    task automatic step(input logic [W-1:0] ai, input logic [W-1:0] bi,
                        input logic eab, input logic eban,
                        input logic sab, input logic sba,
                        input logic ca, input logic cb, input string tag);
        exp_t e;
        @(negedge tclk);
        a_in = ai; b_in = bi;
        en_ab = eab; en_ba_n = eban;
        sel_ab = sab; sel_ba = sba;
        gate_a = ca; gate_b = cb;
        e.a_oe  = !eban;
        e.a_out = !eban ? (sba ? mb : bi) : '0;
        e.b_oe  = eab;
        e.b_out = eab ? (sab ? ma : ai) : '0;
        #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->mon_ev;
        if (ca && rst_n) ma = e.a_oe ? e.a_out : ai;
        if (cb && rst_n) mb = e.b_oe ? e.b_out : bi;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset state: both idle, outputs quiet (R4, R5)
        step(8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R5 idle in reset");
        @(negedge tclk);
        rst_n = 1'b1;

        // R1: cleared registers replay as zero in both directions
        step(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1 reset contents");

        // R6 / R5: live A to B, A side idle
        step(8'hA5, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 live to B");
        // R8 / R4: live B to A, B side idle
        step(8'h00, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 live to A");

        // R2: capture A while idle, then replay on B
        step(8'h5A, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 capture A idle");
        step(8'hFF, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 replay A on B");

        // R3: capture B, A register unaffected
        step(8'h11, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3 capture B idle");
        step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R8 replay both");

        // R10: several cycles of changing inputs, no clock edges
        for (int i = 0; i < 4; i++) begin
            step(8'(i * 37 + 1), 8'(i * 91 + 7), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10 idle churn");
        end
        step(8'hEE, 8'hDD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 hold after churn");

        // R9: A captured while bus A is driven live from B
        step(8'h11, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 capture driven A");
        step(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 replay driven A");

        // R9: B captured while bus B is driven live from A
        step(8'h99, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9 capture driven B");
        step(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 replay driven B");

        // R11: both directions live together
        step(8'h12, 8'h34, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 both live");
        step(8'h80, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 both live bits");

        // R6 / R7: capture patterns and toggle select between live and stored
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] p;
            p = 8'h01 << (i * 2);
            step(p, ~p, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 R3 capture pattern");
            step(~p, p, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 live after capture");
            step(~p, p, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 R8 stored after capture");
        end

        @(negedge tclk);
        gate_a = 1'b0;
        gate_b = 1'b0;
        #10;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule